// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer with Directory Caching

This block caches translations for a two-level page walk. It has 16 sets of 4 ways each. Every way holds a valid bit, a kind flag and a 16-bit tag, plus one 32-bit cached entry. The kind flag is 1 for a first-level (directory) entry and 0 for a second-level (table) entry. A table lookup that hits gives the physical address straight away. On a miss, the walker can ask the block for a cached directory entry before it reads one from memory. Either way, the walker then installs what it fetched through the fill port.

Each cycle, a small decoder picks one operation: OP_FLUSH, OP_FILL, OP_LOOKUP or OP_IDLE. Flush has the highest priority, fill comes next and lookup comes last. A state register holds the operation of the previous cycle. The response outputs are driven from that state. The state moves to OP_LOOKUP when only a lookup is requested. It moves to OP_FILL when a fill is requested without a flush, and to OP_FLUSH when a flush is requested. With no request it moves to OP_IDLE. Every state can be reached from every other state in one cycle. A lookup therefore answers one cycle after it is requested. A task-switch flush clears every entry whose global bit is 0 and keeps every entry whose global bit is 1.

Top module: `tlb_dirc_top`

## Requirements
- R1: After reset, all ways are invalid and `rsp_valid` is 0. A lookup made after reset misses.
- R2: A table lookup takes the page number from `lk_va[31:12]`. It uses bits [3:0] of that page number as the set and bits [19:4] as the tag. It hits when a way in that set is valid, has kind flag 0 and has an equal tag. The result appears on the cycle after the request, with `rsp_valid` set to 1.
- R3: On a table hit, `rsp_entry` is the cached entry. `rsp_pa` is entry bits [31:12] joined with `lk_va[11:0]`.
- R4: A directory lookup uses `lk_va[31:22]` as the directory index. Bits [3:0] of the index choose the set, and the tag is the index zero-extended to 16 bits. A hit needs kind flag 1. A directory entry never satisfies a table lookup, and a table entry never satisfies a directory lookup. On a directory result, `rsp_pa` is 0.
- R5: On a miss, `rsp_hit`, `rsp_entry` and `rsp_pa` are all 0.
- R6: A fill takes its key from `fl_vpn`. The key is built as in R2 for a table fill, or from `fl_vpn[19:10]` as in R4 for a directory fill. The fill writes the way that already holds the same kind and tag, if there is one. Otherwise it writes the lowest-numbered invalid way. If the set is full, it writes the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one (mod 4) only in the full-set case.
- R7: When a fill and a lookup are requested in the same cycle, the fill is performed and the lookup is dropped. `rsp_valid` is 0 on the next cycle.
- R8: A flush invalidates every entry whose cached entry has bit 8 equal to 0 and keeps every entry whose bit 8 is 1. A fill or lookup requested in the same cycle as a flush is dropped.
- R9: No set ever holds two valid ways with the same kind and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_dir | input | 1 | Lookup kind: 1 directory, 0 table |
| lk_va | input | 32 | Virtual address to look up |
| fl_req | input | 1 | Fill request from the walker |
| fl_dir | input | 1 | Fill kind: 1 directory, 0 table |
| fl_vpn | input | 20 | Virtual page number being filled |
| fl_entry | input | 32 | Entry to cache |
| flush_req | input | 1 | Task-switch flush that keeps global entries |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | The lookup hit |
| rsp_dir | output | 1 | Kind of the lookup that produced the result |
| rsp_entry | output | 32 | Cached entry on a hit, else 0 |
| rsp_pa | output | 32 | Physical address on a table hit, else 0 |

## Verification
The embedded assertions are evaluated on every cycle. They check the timing of responses, the dropping of requests that a fill or flush pre-empts, and the zeroed outputs on a miss. They also check that a physical address is formed only for table hits and that no set ever matches on two ways. Which way a fill replaces, whether the round-robin pointer advances, and which entries survive a flush depend on the history of the contents. These only show up in the bench's scenarios, where a behavioural model of the contents is compared with the outputs on every clock.

// File: rtl/tlb_dirc_pkg.sv
package tlb_dirc_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_FILL   = 2'd2,
        OP_FLUSH  = 2'd3
    } tlb_op_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0]            kind_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
    input  logic                       key_kind_i,
    input  logic [TAG_W-1:0]           key_tag_i,
    output logic [WAYS-1:0]            match_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (kind_i[w] == key_kind_i) && (tag_i[w] == key_tag_i);
    end

    assign hit_o = |match_o;

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic             match_hit_i,
    input  logic [WAY_W-1:0] match_way_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             use_rr_o
);
    logic             any_free;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        use_rr_o = 1'b0;
        if (match_hit_i) begin
            way_o = match_way_i;
        end else if (any_free) begin
            way_o = free_way;
        end else begin
            way_o    = rr_i;
            use_rr_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_dirc_top.sv
module tlb_dirc_top
    import tlb_dirc_pkg::*;
#(
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int VPN_W      = 20,
    parameter int OFF_W      = 12,
    parameter int DIR_W      = 10,
    parameter int ENTRY_W    = 32,
    parameter int GLOBAL_BIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic               lk_dir,
    input  logic [31:0]        lk_va,
    input  logic               fl_req,
    input  logic               fl_dir,
    input  logic [19:0]        fl_vpn,
    input  logic [31:0]        fl_entry,
    input  logic               flush_req,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_dir,
    output logic [31:0]        rsp_entry,
    output logic [31:0]        rsp_pa
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int KEY_W = TAG_W + IDX_W;
    localparam int VA_W  = VPN_W + OFF_W;

    // contents
    logic [WAYS-1:0]               valid_q [SETS];
    logic [WAYS-1:0]               kind_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]    tag_q   [SETS];
    logic [WAYS-1:0][ENTRY_W-1:0]  data_q  [SETS];
    logic [WAY_W-1:0]              rr_q    [SETS];

    tlb_op_e op_d, op_q;

    // key formation: table keys split the page number, directory keys reuse the index
    function automatic logic [KEY_W-1:0] key_of(input logic is_dir, input logic [VPN_W-1:0] vpn);
        logic [DIR_W-1:0] d;
        d = vpn[VPN_W-1 -: DIR_W];
        if (is_dir) return {TAG_W'(d), d[IDX_W-1:0]};
        return vpn;
    endfunction

    logic [VPN_W-1:0] lk_vpn;
    logic [KEY_W-1:0] lk_key, fl_key;
    logic [IDX_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;

    assign lk_vpn = lk_va[VA_W-1:OFF_W];
    assign lk_key = key_of(lk_dir, lk_vpn);
    assign fl_key = key_of(fl_dir, fl_vpn);
    assign lk_set = lk_key[IDX_W-1:0];
    assign lk_tag = lk_key[KEY_W-1:IDX_W];
    assign fl_set = fl_key[IDX_W-1:0];
    assign fl_tag = fl_key[KEY_W-1:IDX_W];

    logic [WAYS-1:0]  lk_match, fl_match;
    logic             lk_hit, fl_hit;
    logic [WAY_W-1:0] lk_way, fl_mway, fl_way;
    logic             fl_use_rr;

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
        .valid_i    (valid_q[lk_set]),
        .kind_i     (kind_q[lk_set]),
        .tag_i      (tag_q[lk_set]),
        .key_kind_i (lk_dir),
        .key_tag_i  (lk_tag),
        .match_o    (lk_match),
        .hit_o      (lk_hit),
        .way_o      (lk_way)
    );

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
        .valid_i    (valid_q[fl_set]),
        .kind_i     (kind_q[fl_set]),
        .tag_i      (tag_q[fl_set]),
        .key_kind_i (fl_dir),
        .key_tag_i  (fl_tag),
        .match_o    (fl_match),
        .hit_o      (fl_hit),
        .way_o      (fl_mway)
    );

    tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_i     (valid_q[fl_set]),
        .match_hit_i (fl_hit),
        .match_way_i (fl_mway),
        .rr_i        (rr_q[fl_set]),
        .way_o       (fl_way),
        .use_rr_o    (fl_use_rr)
    );

    // operation decode: flush over fill over lookup
    always_comb begin
        if (flush_req)   op_d = OP_FLUSH;
        else if (fl_req) op_d = OP_FILL;
        else if (lk_req) op_d = OP_LOOKUP;
        else             op_d = OP_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= OP_IDLE;
        else        op_q <= op_d;
    end

    // contents update per decoded operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                kind_q[s]  <= '0;
                tag_q[s]   <= '0;
                data_q[s]  <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            unique case (op_d)
                OP_FLUSH: begin
                    for (int s = 0; s < SETS; s++) begin
                        for (int w = 0; w < WAYS; w++) begin
                            if (!data_q[s][w][GLOBAL_BIT]) valid_q[s][w] <= 1'b0;
                        end
                    end
                end
                OP_FILL: begin
                    valid_q[fl_set][fl_way] <= 1'b1;
                    kind_q[fl_set][fl_way]  <= fl_dir;
                    tag_q[fl_set][fl_way]   <= fl_tag;
                    data_q[fl_set][fl_way]  <= fl_entry;
                    if (fl_use_rr) rr_q[fl_set] <= rr_q[fl_set] + 1'b1;
                end
                OP_LOOKUP, OP_IDLE: ;
            endcase
        end
    end

    // response process, driven by the state
    logic              hit_q, dir_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [VA_W-1:0]    pa_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            dir_q   <= 1'b0;
            entry_q <= '0;
            pa_q    <= '0;
        end else if (op_d == OP_LOOKUP) begin
            hit_q   <= lk_hit;
            dir_q   <= lk_dir;
            entry_q <= lk_hit ? data_q[lk_set][lk_way] : '0;
            pa_q    <= (lk_hit && !lk_dir) ?
                       {data_q[lk_set][lk_way][ENTRY_W-1 -: VPN_W], lk_va[OFF_W-1:0]} : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_dir   = dir_q;
        rsp_entry = '0;
        rsp_pa    = '0;
        unique case (op_q)
            OP_LOOKUP: begin
                rsp_valid = 1'b1;
                rsp_hit   = hit_q;
                rsp_entry = entry_q;
                rsp_pa    = pa_q;
            end
            OP_IDLE, OP_FILL, OP_FLUSH: ;
        endcase
    end

    // assertions
    assert_lookup_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !fl_req && !flush_req) |=> rsp_valid);

    assert_pa_from_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_dir) |-> (rsp_pa[31:12] == rsp_entry[31:12]));

    assert_dir_no_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_dir) |-> (rsp_pa == '0));

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_entry == '0 && rsp_pa == '0));

    assert_fill_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && lk_req) |=> !rsp_valid);

    assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !rsp_valid);

    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fl_match));

    assert_hit_only_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

// File: tb/tlb_dirc_top_tb_top.sv
module tlb_dirc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_dir = 1'b0;
    logic [31:0] lk_va = '0;
    logic        fl_req = 1'b0, fl_dir = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [31:0] fl_entry = '0;
    logic        flush_req = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_dir;
    logic [31:0] rsp_entry, rsp_pa;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tlb_dirc_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_dir(lk_dir), .lk_va(lk_va),
        .fl_req(fl_req), .fl_dir(fl_dir), .fl_vpn(fl_vpn), .fl_entry(fl_entry),
        .flush_req(flush_req),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dir(rsp_dir),
        .rsp_entry(rsp_entry), .rsp_pa(rsp_pa)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_v [16][4];
    bit          m_k [16][4];
    int          m_t [16][4];
    logic [31:0] m_e [16][4];
    int          m_rr [16];
    bit          e_valid, e_hit;
    logic [31:0] e_entry, e_pa;

    function automatic void key(input bit d, input int vpn, output int s, output int t);
        if (d) begin t = vpn >> 10; s = t % 16; end
        else   begin t = vpn >> 4;  s = vpn % 16; end
    endfunction

    always @(posedge clk) begin
        int s, t, w;
        if (!rst_n) begin
            foreach (m_v[i, j]) m_v[i][j] = 0;
            foreach (m_rr[i]) m_rr[i] = 0;
            e_valid = 0;
        end else begin
            e_valid = 0;
            if (flush_req) begin
                foreach (m_v[i, j]) if (!m_e[i][j][8]) m_v[i][j] = 0;
            end else if (fl_req) begin
                key(fl_dir, int'(fl_vpn), s, t);
                w = -1;
                for (int j = 0; j < 4; j++) if (w < 0 && m_v[s][j] && m_k[s][j] == fl_dir && m_t[s][j] == t) w = j;
                for (int j = 0; j < 4; j++) if (w < 0 && !m_v[s][j]) w = j;
                if (w < 0) begin w = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % 4; end
                m_v[s][w] = 1; m_k[s][w] = fl_dir; m_t[s][w] = t; m_e[s][w] = fl_entry;
            end else if (lk_req) begin
                key(lk_dir, int'(lk_va[31:12]), s, t);
                e_valid = 1; e_hit = 0; e_entry = 0; e_pa = 0;
                for (int j = 0; j < 4; j++) if (m_v[s][j] && m_k[s][j] == lk_dir && m_t[s][j] == t) begin
                    e_hit = 1; e_entry = m_e[s][j];
                    if (!lk_dir) e_pa = {m_e[s][j][31:12], lk_va[11:0]};
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R7/R8 model valid", 32'(rsp_valid), 32'(e_valid));
            if (e_valid) begin
                chk("R2/R4/R6 model hit", 32'(rsp_hit), 32'(e_hit));
                chk("R3/R5/R6 model entry", rsp_entry, e_entry);
                chk("R3/R5 model pa", rsp_pa, e_pa);
            end
        end
    end

    task automatic do_fill(input bit d, input logic [19:0] vpn, input logic [31:0] e);
        fl_req = 1; fl_dir = d; fl_vpn = vpn; fl_entry = e;
        @(negedge clk);
        fl_req = 0;
    endtask

    task automatic do_look(input bit d, input logic [31:0] va);
        lk_req = 1; lk_dir = d; lk_va = va;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(rsp_valid), 32'd0);
        do_look(0, 32'h1234_5678);
        chk("R1 empty lookup misses", 32'(rsp_hit), 32'd0);

        // table fill then hit
        do_fill(0, 20'h12345, 32'hABCD_E003);
        do_look(0, 32'h1234_5678);
        chk("R2 table hit", 32'(rsp_hit), 32'd1);
        chk("R3 physical address", rsp_pa, 32'hABCD_E678);
        chk("R3 entry", rsp_entry, 32'hABCD_E003);

        // directory kind
        do_look(1, 32'h1200_0000);
        chk("R4 dir misses on table entry", 32'(rsp_hit), 32'd0);
        do_fill(1, 20'h12345, 32'h0042_0001);
        do_look(1, 32'h1200_0abc);
        chk("R4 dir hit", 32'(rsp_hit), 32'd1);
        chk("R4 dir entry", rsp_entry, 32'h0042_0001);
        chk("R4 dir pa zero", rsp_pa, 32'd0);
        do_look(0, 32'h0048_8000);
        chk("R4 table lookup ignores dir entry", 32'(rsp_hit), 32'd0);
        chk("R5 miss pa zero", rsp_pa, 32'd0);

        // replacement in set 5
        for (int t = 1; t <= 6; t++) do_fill(0, 20'((t << 4) | 5), 32'h0010_0000 * t);
        do_look(0, {20'h00015, 12'h0});
        chk("R6 round-robin evicts first", 32'(rsp_hit), 32'd0);
        do_look(0, {20'h00025, 12'h0});
        chk("R6 round-robin evicts second", 32'(rsp_hit), 32'd0);
        do_look(0, {20'h00035, 12'h0});
        chk("R6 third survives", rsp_entry, 32'h0030_0000);
        do_fill(0, 20'h00035, 32'hCAFE_0000);
        do_look(0, {20'h00035, 12'h123});
        chk("R6 overwrite same tag", rsp_pa, 32'hCAFE_0123);
        do_fill(0, 20'h00075, 32'h0070_0000);
        do_look(0, {20'h00035, 12'h0});
        chk("R6 pointer unchanged by overwrite", 32'(rsp_hit), 32'd0);
        do_look(0, {20'h00045, 12'h0});
        chk("R6 fourth survives", 32'(rsp_hit), 32'd1);

        // fill and lookup together
        lk_req = 1; lk_dir = 0; lk_va = 32'h0BBB_2000;
        fl_req = 1; fl_dir = 0; fl_vpn = 20'h0BBB2; fl_entry = 32'h7777_7000;
        @(negedge clk);
        lk_req = 0; fl_req = 0;
        chk("R7 lookup dropped", 32'(rsp_valid), 32'd0);
        do_look(0, 32'h0BBB_2010);
        chk("R7 fill performed", rsp_pa, 32'h7777_7010);

        // flush keeps global
        do_fill(0, 20'h0AAA1, 32'h5555_5100);
        flush_req = 1; lk_req = 1; lk_va = 32'h0AAA_1000;
        @(negedge clk);
        flush_req = 0; lk_req = 0;
        chk("R8 lookup dropped by flush", 32'(rsp_valid), 32'd0);
        do_look(0, 32'h0AAA_1004);
        chk("R8 global kept", rsp_pa, 32'h5555_5004);
        do_look(0, 32'h1234_5000);
        chk("R8 non-global removed", 32'(rsp_hit), 32'd0);
        do_look(1, 32'h1200_0000);
        chk("R8 dir non-global removed", 32'(rsp_hit), 32'd0);

        // pseudo-random traffic checked by the model (R9 via assertions)
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fl_vpn   = {4'(lfsr[7:5]), 12'h0, 2'b0, lfsr[1:0]} ^ {1'b0, lfsr[4], 18'h0};
            fl_dir   = lfsr[8];
            fl_entry = {lfsr, lfsr[7:0], lfsr[15:8]};
            fl_req   = (lfsr[11:9] < 3'd3);
            lk_req   = (lfsr[11:9] != 3'd7);
            lk_dir   = lfsr[14];
            lk_va    = {fl_vpn ^ {17'h0, lfsr[13:12], 1'b0}, lfsr[11:0]};
            flush_req = (lfsr[15:12] == 4'hF);
            @(negedge clk);
        end
        lk_req = 0; fl_req = 0; flush_req = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule